// File: doc/BRIEF.md
# Skip and Repeat-Suppression Sequencer

This block sits between instruction fetch and execution in a 4-bit controller and decides, for each fetched ROM word, whether that word runs as an instruction, is taken as the operand byte of a two-word instruction, or is discarded as a no-op. It tracks three things across words. The first is a pending skip raised by the instruction just executed. The second is whether the last decoded word was an immediate accumulator load or a B-register byte load, so that repeats of these can be suppressed. The third is whether the next word is a second byte that is owed to an earlier first byte.

The decoder presents a class code for every fetched word. The ALU, the address unit and the flag tests present their skip conditions as a vector of requests. Any condition can serve as a skip source: a zero accumulator, one of the flags FF1, FF2 or C being set, carry-out of an add-and-skip or of the immediate add, or a wrap of the low B nibble on increment or decrement. The block collects these requests only from a word that actually executes.

Which conditions raise a request is the job of the units that produce them. For example, the immediate add requests a skip on its own carry-out without reading or writing C, and the decimal correction never requests one.

Top module: `skip_suppress_seq`

## Requirements
- R1: After reset, the outputs `skip_pending`, `imm_run`, `bload_run` and `operand_due` are all 0, and the first valid word of class other executes.
- R2: If a word executes while any bit of `skip_req` is 1, the next valid word that is not an owed operand has `exec_en`=0 and `operand_en`=0.
- R3: A skipped word of class two-word (code 4) or long B load (code 3) discards only itself. The next valid word is decoded as a new instruction, and a class other (code 0) word there executes.
- R4: In a run of consecutive valid words of class immediate load (code 1), only the first has `exec_en`=1.
- R5: In a run of consecutive B loads, only the first has `exec_en`=1. The run may use short form (code 2), long form (code 3) or any mix of the two.
- R6: A long B load that is suppressed takes its following valid word with it, and that word has `exec_en`=0 and `operand_en`=0. After that word, the B run is still active.
- R7: An executing word of code 3 or 4 makes the next valid word an operand, with `operand_en`=1 and `exec_en`=0. The operand word does not change `imm_run`, `bload_run` or `skip_pending`.
- R8: A word discarded by a skip clears both `imm_run` and `bload_run`, so the next load of either kind executes.
- R9: A valid word outside a run's class ends that run. This applies to class other and to codes 5 to 7, which are treated as other.
- R10: `skip_req` has no effect in a cycle where `exec_en` is 0.
- R11: While `word_valid` is 0, `exec_en` and `operand_en` are 0 and all state outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | A fetched ROM word is present this cycle |
| word_class | input | 3 | Decoded class: 0 other, 1 immediate load, 2 short B load, 3 long B load, 4 two-word |
| skip_req | input | NSRC | Skip conditions raised for the current word |
| exec_en | output | 1 | Current word executes as an instruction |
| operand_en | output | 1 | Current word is taken as the operand byte of an executing two-word instruction |
| skip_pending | output | 1 | Next non-operand word will be discarded |
| imm_run | output | 1 | Last decoded word was an immediate load |
| bload_run | output | 1 | Last decoded word was a B load |
| operand_due | output | 1 | Next valid word is a second byte |

## Verification
The bench aims at several sequences that are easy to get wrong:
- A skip landing on a two-word first byte. A design that also swallowed the second byte would lose the instruction that follows.
- A long-short-long B load mix. A wrong design would either execute the later loads or decode the ignored long form's operand as an instruction.
- Load runs cut by a skip or by an unrelated word. Here a faulty design keeps suppressing loads that should run.
- Skip requests raised on suppressed or operand words. A leaky design would discard a healthy instruction.
- Idle fetch cycles, which must neither advance nor clear any tracking flag.

// File: rtl/skipseq_pkg.sv
package skipseq_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        WC_OTHER  = 3'd0,
        WC_IMM    = 3'd1,
        WC_BSHORT = 3'd2,
        WC_BLONG  = 3'd3,
        WC_PAIR   = 3'd4
    } word_class_e;

    typedef struct packed {
        logic skip_pend;
        logic imm_run;
        logic bload_run;
        logic op_due;
        logic op_live;
    } seq_state_t;

endpackage

// File: rtl/skip_collect.sv
module skip_collect #(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0] req,
    input  logic            gate,
    output logic            any_skip
);
    logic [NSRC:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_or
            assign chain[i+1] = chain[i] | req[i];
        end
    endgenerate

    assign any_skip = gate & chain[NSRC];
endmodule

// File: rtl/run_filter.sv
module run_filter
    import skipseq_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic             imm_run_q,
    input  logic             bload_run_q,
    output logic             is_imm,
    output logic             is_bload,
    output logic             has_second,
    output logic             suppress
);
    always_comb begin
        is_imm     = 1'b0;
        is_bload   = 1'b0;
        has_second = 1'b0;
        case (cls)
            WC_IMM:    is_imm = 1'b1;
            WC_BSHORT: is_bload = 1'b1;
            WC_BLONG: begin
                is_bload   = 1'b1;
                has_second = 1'b1;
            end
            WC_PAIR:   has_second = 1'b1;
            default:   ;
        endcase
        suppress = (is_imm & imm_run_q) | (is_bload & bload_run_q);
    end
endmodule

// File: rtl/skip_suppress_seq.sv
module skip_suppress_seq
    import skipseq_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic [CLS_W-1:0] word_class,
    input  logic [NSRC-1:0]  skip_req,
    output logic             exec_en,
    output logic             operand_en,
    output logic             skip_pending,
    output logic             imm_run,
    output logic             bload_run,
    output logic             operand_due
);
    seq_state_t st_q, st_d;

    logic is_imm, is_bload, has_second, suppress;
    logic exec_go, any_skip, opnd_go;

    run_filter u_filter (
        .cls        (word_class),
        .imm_run_q  (st_q.imm_run),
        .bload_run_q(st_q.bload_run),
        .is_imm     (is_imm),
        .is_bload   (is_bload),
        .has_second (has_second),
        .suppress   (suppress)
    );

    // a word runs only when no operand is owed, no skip waits and no run repeats
    assign exec_go = word_valid & ~st_q.op_due & ~st_q.skip_pend & ~suppress;

    skip_collect #(.NSRC(NSRC)) u_skip (
        .req     (skip_req),
        .gate    (exec_go),
        .any_skip(any_skip)
    );

    always_comb begin
        st_d    = st_q;
        opnd_go = 1'b0;
        if (word_valid) begin
            if (st_q.op_due) begin
                // second byte: taken or dropped with its owner, runs untouched
                opnd_go      = st_q.op_live;
                st_d.op_due  = 1'b0;
                st_d.op_live = 1'b0;
            end else if (st_q.skip_pend) begin
                // discarded word: one word only, and it breaks any run
                st_d.skip_pend = 1'b0;
                st_d.imm_run   = 1'b0;
                st_d.bload_run = 1'b0;
            end else if (suppress) begin
                st_d.imm_run   = is_imm;
                st_d.bload_run = is_bload;
                st_d.op_due    = has_second;
                st_d.op_live   = 1'b0;
            end else begin
                st_d.imm_run   = is_imm;
                st_d.bload_run = is_bload;
                st_d.op_due    = has_second;
                st_d.op_live   = has_second;
                st_d.skip_pend = any_skip;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exec_en      = exec_go;
    assign operand_en   = opnd_go;
    assign skip_pending = st_q.skip_pend;
    assign imm_run      = st_q.imm_run;
    assign bload_run    = st_q.bload_run;
    assign operand_due  = st_q.op_due;
endmodule

// File: rtl/skip_seq_chk.sv
module skip_seq_chk #(
    parameter int NSRC = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            word_valid,
    input logic [2:0]      word_class,
    input logic [NSRC-1:0] skip_req,
    input logic            exec_en,
    input logic            operand_en,
    input logic            skip_pending,
    input logic            imm_run,
    input logic            bload_run,
    input logic            operand_due
);
    // R7: a word is never both instruction and operand
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_en && operand_en));

    // R2: a pending skip blocks the next non-operand word and is then consumed
    a_r2_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && skip_pending && !operand_due |-> !exec_en && !operand_en);

    a_r2_skip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && skip_pending && !operand_due |=> !skip_pending);

    // R8: a discarded word ends both runs
    a_r8_run_break: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && skip_pending && !operand_due |=> !imm_run && !bload_run);

    // R4: a repeated immediate load stays idle
    a_r4_imm_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && imm_run && !skip_pending && !operand_due && word_class == 3'd1
        |-> !exec_en);

    // R5: a repeated B load stays idle
    a_r5_bload_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && bload_run && !skip_pending && !operand_due
        && (word_class == 3'd2 || word_class == 3'd3) |-> !exec_en);

    // R7: an operand word leaves the run and skip flags alone
    a_r7_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && operand_due |=> $stable(imm_run) && $stable(bload_run) && $stable(skip_pending));

    // R10: a word that does not run cannot raise a skip
    a_r10_no_leak: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !exec_en && !operand_due |=> !skip_pending);

    // R11: idle fetch cycles change nothing
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> !exec_en && !operand_en);

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(skip_pending) && $stable(imm_run) && $stable(bload_run) && $stable(operand_due));
endmodule

bind skip_suppress_seq skip_seq_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_class  (word_class),
    .skip_req    (skip_req),
    .exec_en     (exec_en),
    .operand_en  (operand_en),
    .skip_pending(skip_pending),
    .imm_run     (imm_run),
    .bload_run   (bload_run),
    .operand_due (operand_due)
);

// File: tb/tb_skip_suppress_seq.sv
module tb_skip_suppress_seq;
    localparam int NSRC = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            word_valid = 1'b0;
    logic [2:0]      word_class = 3'd0;
    logic [NSRC-1:0] skip_req = '0;
    logic exec_en, operand_en, skip_pending, imm_run, bload_run, operand_due;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference state, derived from the requirements
    logic m_skip, m_imm, m_bl, m_due, m_live;

    always #2 clk = ~clk;

    skip_suppress_seq #(.NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_class(word_class),
        .skip_req(skip_req), .exec_en(exec_en), .operand_en(operand_en),
        .skip_pending(skip_pending), .imm_run(imm_run), .bload_run(bload_run),
        .operand_due(operand_due)
    );

    function automatic logic [5:0] expect_out(input logic v, input logic [2:0] c);
        logic ex, op;
        logic is_i, is_b;
        is_i = (c == 3'd1);
        is_b = (c == 3'd2) || (c == 3'd3);
        ex = 1'b0;
        op = 1'b0;
        if (v) begin
            if (m_due)       op = m_live;
            else if (!m_skip) ex = !((is_i && m_imm) || (is_b && m_bl));
        end
        return {ex, op, m_skip, m_imm, m_bl, m_due};
    endfunction

    task automatic model_step(input logic v, input logic [2:0] c, input logic [NSRC-1:0] s);
        logic is_i, is_b, two;
        is_i = (c == 3'd1);
        is_b = (c == 3'd2) || (c == 3'd3);
        two  = (c == 3'd3) || (c == 3'd4);
        if (!v) return;
        if (m_due) begin
            m_due = 1'b0; m_live = 1'b0;
        end else if (m_skip) begin
            m_skip = 1'b0; m_imm = 1'b0; m_bl = 1'b0;
        end else if ((is_i && m_imm) || (is_b && m_bl)) begin
            m_imm = is_i; m_bl = is_b; m_due = two; m_live = 1'b0;
        end else begin
            m_imm = is_i; m_bl = is_b; m_due = two; m_live = two; m_skip = (s != '0);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] c, input logic [NSRC-1:0] s,
                        input string tag);
        logic [5:0] exp_v, act;
        @(negedge clk);
        word_valid = v; word_class = c; skip_req = s;
        #1;
        exp_v = expect_out(v, c);
        act = {exec_en, operand_en, skip_pending, imm_run, bload_run, operand_due};
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: {exec,opnd,skip,imm,bl,due} actual=%b expected=%b", tag, act, exp_v);
        end
        model_step(v, c, s);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_skip = 0; m_imm = 0; m_bl = 0; m_due = 0; m_live = 0;
        repeat (3) @(posedge clk);
        step(1'b0, 3'd0, '0, "R1 reset state");
        @(negedge clk); rst_n = 1'b1;
        step(1'b1, 3'd0, '0, "R1 first word runs");

        // R4: immediate load run, then R9 break by other
        step(1'b1, 3'd1, '0, "R4 first imm");
        step(1'b1, 3'd1, 6'b000001, "R4 second imm, R10 skip ignored");
        step(1'b1, 3'd1, '0, "R4 third imm");
        step(1'b1, 3'd0, '0, "R9 other breaks");
        step(1'b1, 3'd1, '0, "R9 imm runs again");

        // R5/R6: long, short, long mix
        step(1'b1, 3'd3, '0, "R5 long B runs");
        step(1'b1, 3'd5, '0, "R7 operand of long B");
        step(1'b1, 3'd2, '0, "R5 short B suppressed");
        step(1'b1, 3'd3, '0, "R5 long B suppressed");
        step(1'b1, 3'd1, 6'b100000, "R6 dropped operand");
        step(1'b1, 3'd2, '0, "R6 B run still active");
        step(1'b0, 3'd1, 6'b111111, "R11 idle");
        step(1'b1, 3'd7, '0, "R9 code 7 breaks B run");

        // R2/R3: skip landing on two-word first byte
        step(1'b1, 3'd0, 6'b000100, "R2 skip raised");
        step(1'b0, 3'd0, '0, "R11 idle holds skip");
        step(1'b1, 3'd4, '0, "R3 pair skipped");
        step(1'b1, 3'd0, '0, "R3 next byte decoded");

        // R8: skip cuts a B run
        step(1'b1, 3'd2, 6'b010000, "R8 B load raises skip");
        step(1'b1, 3'd2, '0, "R8 skipped word");
        step(1'b1, 3'd3, '0, "R8 B load runs after skip");
        step(1'b1, 3'd0, 6'b000010, "R7 operand skip ignored");
        step(1'b1, 3'd1, '0, "R7 imm after operand");

        // random stimulus
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [2:0] c;
            logic [NSRC-1:0] s;
            v = ($urandom % 8) != 0;
            c = 3'(($urandom % 3 == 0) ? ($urandom % 8) : (1 + $urandom % 3));
            s = ($urandom % 5 == 0) ? NSRC'(1 << ($urandom % NSRC)) : '0;
            step(v, c, s, "random R2 R4 R5 R7 R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule